// File: doc/BRIEF.md
# Glitch-Free Five-Way Clock Source Selector

This block drives the clock of one clock domain from one of five input clocks: the main oscillator, a slow real-time oscillator and three PLL outputs. Software picks the source by writing a three-bit index through a small register port on a bus clock. The handover never makes a shortened pulse on the output. The lane of the old source is switched off on that source's own falling edge. Only after the bus side has seen that lane go quiet is the lane of the new source switched on, on the new source's own falling edge.

During a handover a busy flag in the readback word stays set. Software writes the index and polls the flag until it drops, and only then relies on the new clock. An index outside the five legal codes is discarded. A write of the index that is already active starts nothing. A write that arrives while a handover is running is dropped.

Top module: `clk_src_sel`

## Requirements
- R1: A synchronous reset sets the select index to 0 (oscillator). Once the oscillator lane is engaged, busy reads 0 and `clk_out` follows `src_clk[0]`.
- R2: `rd_data` always shows the programmed index in bits [2:0] and busy in bit 3, with all higher bits zero.
- R3: When busy is 0, a write of a legal index (0 to 4) that differs from the current index is accepted. On the cycle after the write, bits [2:0] read the new index and busy reads 1.
- R4: A write of index 5, 6 or 7 is ignored. The index is unchanged, busy stays 0 and `clk_out` keeps following the previous source.
- R5: A write made while busy reads 1 is ignored, and the programmed index is unchanged.
- R6: A write of the index that is already active starts no handover, and busy stays 0.
- R7: At no time are two source lanes engaged together. `clk_out` never shows a high or low phase shorter than the shortest half period of the sources involved.
- R8: After busy clears, `clk_out` follows the source whose index was written.
- R9: Busy clears only after the bus side has seen that the lane of the new source is engaged and that every other lane is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus_clk domain |
| wr_en | input | 1 | Write strobe for the select field |
| wr_sel | input | 3 | Source index to write (0 osc, 1 rtc, 2..4 PLL outputs) |
| rd_data | output | CFG_W | Readback: [2:0] index, [3] busy, rest zero |
| src_clk | input | 5 | Candidate clocks, bit n is source index n |
| clk_out | output | 1 | Selected domain clock |

## Verification
A wrong handover state first shows on `clk_out`. If two lanes overlap, or a lane turns off in mid-phase, the output shows a pulse narrower than any source half period within one source cycle of the handover. If the lane state is right but the select state is wrong, the output settles on a clock other than the one requested, and this shows as soon as busy drops. Bad accept logic shows one bus cycle after the write: the readback word holds the wrong index, or busy has the wrong level. A busy flag that hangs shows as a poll that never completes.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int NUM_SRC = 5;
    localparam int SEL_W   = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [SEL_W-1:0]   sel_idx_t;

    // Handover sequencer states
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,   // waiting for oscillator lane after reset
        ST_IDLE  = 2'd1,   // stable, writes accepted
        ST_DROP  = 2'd2,   // old lane released, waiting for it to go quiet
        ST_RAISE = 2'd3    // new lane requested, waiting for its engagement
    } hand_st_e;

    // Captured write request
    typedef struct packed {
        logic     valid;
        sel_idx_t idx;
    } sel_req_t;

    function automatic logic sel_legal(sel_idx_t s);
        return int'(s) < NUM_SRC;
    endfunction

    function automatic src_vec_t sel_onehot(sel_idx_t s);
        src_vec_t v;
        v = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(s) == i) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_lane.sv
module clk_lane #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic req,
    output logic gate
);
    logic req_s;
    logic gate_q;

    // Bring the bus-side request into this source's domain
    sync_chain #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk (src_clk),
        .d   (req),
        .q   (req_s)
    );

    // Change the gate only while the source is low, so no pulse is cut
    always_ff @(negedge src_clk) begin
        gate_q <= req_s;
    end

    assign gate = gate_q;
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
    import clksel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sel_req_t wreq,
    input  src_vec_t ack,
    output src_vec_t req,
    output sel_idx_t sel,
    output logic     busy
);
    hand_st_e st_q;
    src_vec_t req_q;
    sel_idx_t sel_q;
    logic     accept;

    assign accept = (st_q == ST_IDLE) && wreq.valid &&
                    sel_legal(wreq.idx) && (wreq.idx != sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_BOOT;
            sel_q <= '0;
            req_q <= sel_onehot('0);
        end else begin
            unique case (st_q)
                ST_BOOT: begin
                    if (ack == req_q) st_q <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (accept) begin
                        sel_q <= wreq.idx;
                        req_q <= '0;
                        st_q  <= ST_DROP;
                    end
                end
                ST_DROP: begin
                    if (ack == '0) begin
                        req_q <= sel_onehot(sel_q);
                        st_q  <= ST_RAISE;
                    end
                end
                ST_RAISE: begin
                    if (ack == req_q) st_q <= ST_IDLE;
                end
                default: st_q <= ST_BOOT;
            endcase
        end
    end

    assign req  = req_q;
    assign sel  = sel_q;
    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
    import clksel_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 bus_clk,
    input  logic                 bus_rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    output logic [CFG_W-1:0]     rd_data,
    input  logic [NUM_SRC-1:0]   src_clk,
    output logic                 clk_out
);
    localparam int BUSY_BIT = SEL_W;

    sel_req_t wreq;
    src_vec_t req_vec;
    src_vec_t gate_vec;
    src_vec_t ack_vec;
    src_vec_t gated;
    sel_idx_t sel_cur;
    logic     busy;

    assign wreq.valid = wr_en;
    assign wreq.idx   = wr_sel;

    sel_ctrl u_ctrl (
        .clk  (bus_clk),
        .rst  (bus_rst),
        .wreq (wreq),
        .ack  (ack_vec),
        .req  (req_vec),
        .sel  (sel_cur),
        .busy (busy)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        clk_lane #(.STAGES(SYNC_STAGES)) u_lane (
            .src_clk (src_clk[i]),
            .req     (req_vec[i]),
            .gate    (gate_vec[i])
        );
        assign gated[i] = src_clk[i] & gate_vec[i];
    end

    // Lane engagement seen from the bus side
    sync_chain #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (bus_clk),
        .d   (gate_vec),
        .q   (ack_vec)
    );

    assign clk_out = |gated;

    always_comb begin
        rd_data                 = '0;
        rd_data[SEL_W-1:0]      = sel_cur;
        rd_data[BUSY_BIT]       = busy;
    end
endmodule

// File: rtl/clk_src_sel_chk.sv
module clk_src_sel_chk
    import clksel_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input logic             bus_clk,
    input logic             bus_rst,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [CFG_W-1:0] rd_data,
    input src_vec_t         gate_vec,
    input src_vec_t         ack_vec
);
    logic     busy_r;
    sel_idx_t sel_r;
    assign busy_r = rd_data[SEL_W];
    assign sel_r  = rd_data[SEL_W-1:0];

    AST_LANES_EXCLUSIVE: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $onehot0(gate_vec)); // R7

    AST_START_HANDOVER: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && !busy_r && (int'(wr_sel) < NUM_SRC) && (wr_sel != sel_r))
        |=> (busy_r && (sel_r == $past(wr_sel)))); // R3

    AST_BAD_INDEX_IGNORED: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && !busy_r && (int'(wr_sel) >= NUM_SRC))
        |=> ($stable(sel_r) && !busy_r)); // R4

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && busy_r) |=> $stable(sel_r)); // R5

    AST_SAME_INDEX_QUIET: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && !busy_r && (wr_sel == sel_r)) |=> !busy_r); // R6

    AST_DONE_AFTER_ACK: assert property (@(posedge bus_clk) disable iff (bus_rst)
        $fell(busy_r) |-> (ack_vec == sel_onehot(sel_r))); // R9
endmodule

bind clk_src_sel clk_src_sel_chk #(.CFG_W(CFG_W)) i_chk (
    .bus_clk  (bus_clk),
    .bus_rst  (bus_rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .rd_data  (rd_data),
    .gate_vec (gate_vec),
    .ack_vec  (ack_vec)
);

// File: tb/test_clk_src_sel.sv
`timescale 1ns/1ps
module test_clk_src_sel;
    localparam int CFG_W = 8;

    logic             bus_clk = 1'b0;
    logic             bus_rst = 1'b1;
    logic             wr_en   = 1'b0;
    logic [2:0]       wr_sel  = '0;
    logic [CFG_W-1:0] rd_data;
    logic [4:0]       src_clk = '0;
    logic             clk_out;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int runts = 0;
    bit done  = 0;
    realtime t_rise = 0.0;
    realtime t_fall = 0.0;

    typedef struct {
        int              cyc;
        logic [CFG_W-1:0] val;
        string           tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    clk_src_sel #(.CFG_W(CFG_W)) i_clk_src_sel (
        .bus_clk (bus_clk),
        .bus_rst (bus_rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .rd_data (rd_data),
        .src_clk (src_clk),
        .clk_out (clk_out)
    );

    always #2 bus_clk = ~bus_clk;   // 250 MHz
    initial begin #0.123; forever #3.317  src_clk[0] = ~src_clk[0]; end
    initial begin #0.231; forever #25.013 src_clk[1] = ~src_clk[1]; end
    initial begin #0.347; forever #2.711  src_clk[2] = ~src_clk[2]; end
    initial begin #0.419; forever #4.129  src_clk[3] = ~src_clk[3]; end
    initial begin #0.577; forever #6.077  src_clk[4] = ~src_clk[4]; end

    always @(posedge bus_clk) cyc <= cyc + 1;

    // Pulse width monitor for R7
    always @(posedge clk_out) begin
        if (!bus_rst && t_fall > 0.0 && ($realtime - t_fall) < 2.6) runts++;
        t_rise = $realtime;
    end
    always @(negedge clk_out) begin
        if (!bus_rst && t_rise > 0.0 && ($realtime - t_rise) < 2.6) runts++;
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string tag,
                         input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Scoreboard monitor: compare readback against queued expectations
    always @(negedge bus_clk) begin
        if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(rd_data == it.val, it.tag, int'(rd_data), int'(it.val));
        end
    end

    // Driver: one write strobe, expected readback queued for next cycle
    task automatic do_write(input logic [2:0] v, input logic [CFG_W-1:0] exp_v,
                            input string tag);
        exp_item_t it;
        @(negedge bus_clk);
        wr_en  = 1'b1;
        wr_sel = v;
        it.cyc = cyc + 1;
        it.val = exp_v;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k;
        k = 0;
        while (rd_data[3] && k < 500) begin
            @(negedge bus_clk);
            k++;
        end
        check(!rd_data[3], tag, int'(rd_data[3]), 0);
    endtask

    task automatic check_follow(input int idx, input string tag);
        int bad;
        bad = 0;
        for (int s = 0; s < 100; s++) begin
            @(negedge bus_clk);
            if (clk_out != src_clk[idx]) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge bus_clk);
        check(rd_data[2:0] == 3'd0, "R1 reset index", int'(rd_data[2:0]), 0);
        bus_rst = 1'b0;
        wait_idle("R1 busy after reset");
        check(rd_data == 8'h00, "R2 idle readback", int'(rd_data), 0);
        check_follow(0, "R1 follows oscillator");

        do_write(3'd2, 8'h0A, "R3 accept index 2");
        do_write(3'd4, 8'h0A, "R5 write during busy");
        wait_idle("R9 handover to 2 completes");
        check(rd_data == 8'h02, "R2 readback index 2", int'(rd_data), 8'h02);
        check_follow(2, "R8 follows source 2");

        do_write(3'd6, 8'h02, "R4 invalid index 6");
        do_write(3'd7, 8'h02, "R4 invalid index 7");
        check_follow(2, "R4 clock kept after invalid");

        do_write(3'd2, 8'h02, "R6 same index");
        check_follow(2, "R6 clock kept after same index");

        do_write(3'd1, 8'h09, "R3 accept index 1");
        wait_idle("R9 handover to 1 completes");
        check_follow(1, "R8 follows source 1");

        do_write(3'd0, 8'h08, "R3 accept index 0");
        wait_idle("R9 handover to 0 completes");
        check_follow(0, "R8 follows source 0");

        do_write(3'd3, 8'h0B, "R3 accept index 3");
        wait_idle("R9 handover to 3 completes");
        check_follow(3, "R8 follows source 3");

        do_write(3'd4, 8'h0C, "R3 accept index 4");
        wait_idle("R9 handover to 4 completes");
        check(rd_data == 8'h04, "R2 readback index 4", int'(rd_data), 8'h04);
        check_follow(4, "R8 follows source 4");

        repeat (4) @(negedge bus_clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        check(runts == 0, "R7 no short pulses", runts, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule